// File: doc/BRIEF.md
# Multi-Size Page Translation Buffer

This block is a small, fully associative address translation buffer. Software loads 64-bit translation entries one at a time through a write port, addressed by slot index. Every cycle a requester may present a 32-bit virtual address together with its 7-bit address-space tag, the kind of access (read, write or execute) and whether it runs in user mode. One clock later the block reports whether a slot matched, which slot it was, the 36-bit physical address and whether the access breaks the slot's permissions.

Each slot carries its own page size, from 4 KB up to 16 MB, so each slot masks a different number of virtual address bits. The size is encoded inside the entry: a dedicated small-page flag selects 4 KB, and otherwise the lowest set bit among physical page bits 1..6 picks one of six larger sizes. Attribute bits for caching are kept in the entry but have no effect. There is no control state machine. The single pipeline register between the combinational lookup and the response ports is the only sequencing stage. Slots are compared in parallel, and a fixed priority picks the lowest matching index.

Top module: `tlb_lookup`

## Requirements
- R1: After reset `rsp_valid`, `rsp_hit` and `rsp_fault` are 0 and every slot is empty, so any lookup misses.
- R2: A slot whose bit 63 (present) is 0 never matches. A miss returns `rsp_hit`=0, `rsp_idx`=0, `rsp_paddr`=0 and `rsp_fault`=0.
- R3: If bit 62 (shared) of a slot is 1, the 7-bit tag in bits 58..52 is ignored. Otherwise the tag must equal `lk_asid` for the slot to match.
- R4: Entry layout: bit 61 is the top physical bit, bits 51..32 are the virtual page (VA 31..12) and bits 23..1 are the physical page (PA 34..12). If bit 0 is 1, the page is 4 KB and PA = {bit61, bits 23..1, VA[11:0]}.
- R5: If bit 0 is 0 and the lowest set physical page bit j lies in 1..6, the page is 2^(12+2j) bytes (16 KB, 64 KB, 256 KB, 1 MB, 4 MB, 16 MB). Only VA bits 31..12+2j are compared, and PA bits 11+2j..0 come from the VA.
- R6: A slot with bit 0 clear and no set bit among physical page bits 1..6 never matches.
- R7: `lk_kind` is 00 read, 01 write, 10 execute, 11 reserved (always faults). The enables are bit 29 read, bit 30 write and bit 31 execute. User mode also needs bit 28; supervisor mode ignores bit 28. A hit that fails these checks sets `rsp_fault` and keeps `rsp_hit`=1.
- R8: Bits 60..59 and 27..24 have no effect on matching, address or fault.
- R9: If several slots match, the lowest index is reported.
- R10: The response appears the cycle after `lk_valid`. A slot written in one cycle is used by lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load a slot |
| wr_idx | input | IDX_W | Slot to load |
| wr_data | input | 64 | Entry contents |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 7 | Requester address-space tag |
| lk_kind | input | 2 | Access kind |
| lk_user | input | 1 | User-mode access |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A slot matched |
| rsp_idx | output | IDX_W | Matching slot |
| rsp_paddr | output | 36 | Physical address |
| rsp_fault | output | 1 | Permission fault on hit |

## Verification
The assertions assume that `lk_valid` and the write port are driven to known values during and after reset. Under that assumption the response register follows the request one cycle later, and on a hit the 12-bit page offset always passes through unchanged. The stimulus holds both request strobes low through reset. It writes and looks up on separate cycles, so each lookup sees slot contents that have settled. The addresses are chosen so that each lookup matches only the slots the check intends.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    localparam int ENTRY_W = 64;
    localparam int VA_W    = 32;
    localparam int PA_W    = 36;
    localparam int TAG_W   = 7;
    localparam int VPN_W   = 20;
    localparam int PPN_W   = 23;
    localparam int MAX_MARK = 6;
endpackage

// File: rtl/tlb_slot_match.sv
module tlb_slot_match
    import tlb_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic [VA_W-1:0]    va,
    input  logic [TAG_W-1:0]   asid,
    input  logic [1:0]         kind,
    input  logic               user,
    output logic               match,
    output logic [PA_W-1:0]    pa,
    output logic               allow
);
    logic               present, shared, xp, small_pg, size_ok;
    logic               en_x, en_w, en_r, en_u, kind_en;
    logic [TAG_W-1:0]   tag;
    logic [VPN_W-1:0]   vpn, vmask;
    logic [PPN_W-1:0]   ppn;
    logic [3:0]         low_cnt;
    logic [VA_W-1:0]    va_keep;

    assign present  = entry[63];
    assign shared   = entry[62];
    assign xp       = entry[61];
    assign tag      = entry[58:52];
    assign vpn      = entry[51:32];
    assign en_x     = entry[31];
    assign en_w     = entry[30];
    assign en_r     = entry[29];
    assign en_u     = entry[28];
    assign ppn      = entry[23:1];
    assign small_pg = entry[0];

    always_comb begin
        size_ok = 1'b1;
        low_cnt = 4'd0;
        if (!small_pg) begin
            size_ok = 1'b0;
            for (int j = MAX_MARK; j >= 1; j--) begin
                if (ppn[j]) begin
                    size_ok = 1'b1;
                    low_cnt = 4'(2 * j);
                end
            end
        end
    end

    assign vmask   = {VPN_W{1'b1}} << low_cnt;
    assign va_keep = ~{vmask, 12'h000};

    assign match = present && size_ok && (shared || (tag == asid))
                   && ((va[31:12] & vmask) == (vpn & vmask));

    assign pa = {xp, ppn & {3'b111, vmask}, 12'h000} | {4'h0, va & va_keep};

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_READ:  kind_en = en_r;
            ACC_WRITE: kind_en = en_w;
            ACC_EXEC:  kind_en = en_x;
            default:   kind_en = 1'b0;
        endcase
    end

    assign allow = kind_en && (!user || en_u);
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [63:0]        wr_data,
    input  logic               lk_valid,
    input  logic [31:0]        lk_vaddr,
    input  logic [6:0]         lk_asid,
    input  logic [1:0]         lk_kind,
    input  logic               lk_user,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [IDX_W-1:0]   rsp_idx,
    output logic [35:0]        rsp_paddr,
    output logic               rsp_fault
);
    logic [ENTRY_W-1:0]  slots   [NUM_ENTRIES];
    logic [PA_W-1:0]     pa_arr  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hit_vec, allow_vec;
    logic                any_hit;
    logic [IDX_W-1:0]    sel_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) slots[i] <= '0;
        end else if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        tlb_slot_match u_match (
            .entry (slots[g]),
            .va    (lk_vaddr),
            .asid  (lk_asid),
            .kind  (lk_kind),
            .user  (lk_user),
            .match (hit_vec[g]),
            .pa    (pa_arr[g]),
            .allow (allow_vec[g])
        );
    end

    tlb_prio_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .req (hit_vec),
        .any (any_hit),
        .idx (sel_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && any_hit;
            rsp_idx   <= (lk_valid && any_hit) ? sel_idx : '0;
            rsp_paddr <= (lk_valid && any_hit) ? pa_arr[sel_idx] : '0;
            rsp_fault <= lk_valid && any_hit && !allow_vec[sel_idx];
        end
    end
endmodule

// File: rtl/tlb_lookup_checker.sv
module tlb_lookup_checker #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [31:0]      lk_vaddr,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [IDX_W-1:0] rsp_idx,
    input logic [35:0]      rsp_paddr,
    input logic             rsp_fault
);
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid && !rsp_hit);
    a_r7_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);
    a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_idx == '0) && (rsp_paddr == '0) && !rsp_fault);
    a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> !rsp_hit || (rsp_paddr[11:0] == $past(lk_vaddr[11:0])));
endmodule

bind tlb_lookup tlb_lookup_checker #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_idx   (rsp_idx),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/tlb_lookup_bench.sv
module tlb_lookup_bench;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic lk_valid = 1'b0, lk_user = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [6:0] lk_asid = '0;
    logic [1:0] lk_kind = '0;
    logic rsp_valid, rsp_hit, rsp_fault;
    logic [IW-1:0] rsp_idx;
    logic [35:0] rsp_paddr;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic          hit;
        logic [IW-1:0] idx;
        logic [35:0]   pa;
        logic          fault;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #5ns clk = ~clk;

    tlb_lookup #(.NUM_ENTRIES(N)) u_tlb_lookup (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_kind(lk_kind),
        .lk_user(lk_user), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    function automatic logic [63:0] mk(bit v, bit g, bit xp, logic [1:0] la, logic [6:0] tg,
                                       logic [19:0] vpn, bit x, bit w, bit r, bit u,
                                       logic [3:0] ca, logic [22:0] ppn, bit s);
        return {v, g, xp, la, tg, vpn, x, w, r, u, ca, ppn, s};
    endfunction

    task automatic wr(input int i, input logic [63:0] d);
        @(negedge clk);
        lk_valid = 1'b0; wr_en = 1'b1; wr_idx = IW'(i); wr_data = d;
    endtask

    task automatic look(input logic [31:0] va, input logic [6:0] tg, input logic [1:0] k,
                        input bit usr, input bit eh, input int ei, input logic [35:0] ep,
                        input bit ef, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b1; lk_vaddr = va; lk_asid = tg; lk_kind = k; lk_user = usr;
        e.hit = eh; e.idx = IW'(ei); e.pa = ep; e.fault = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R10: response with nothing expected");
            end else begin
                e = sb.pop_front();
                if (rsp_hit !== e.hit || rsp_idx !== e.idx || rsp_paddr !== e.pa || rsp_fault !== e.fault) begin
                    errors++;
                    $display("FAIL %s: got hit=%0b idx=%0d pa=%h fault=%0b, expected hit=%0b idx=%0d pa=%h fault=%0b",
                             e.tag, rsp_hit, rsp_idx, rsp_paddr, rsp_fault, e.hit, e.idx, e.pa, e.fault);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_fault !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs v=%0b h=%0b f=%0b, expected 0 0 0", rsp_valid, rsp_hit, rsp_fault);
        end
        look(32'h12345678, 7'h00, 2'b00, 1'b0, 0, 0, 36'h0, 0, "R1 empty after reset");

        wr(0, mk(0,1,0,2'b00,7'h00,20'h12345,1,1,1,1,4'h0,23'h000100,1));
        wr(1, mk(1,0,1,2'b00,7'h15,20'hABCDE,1,1,1,1,4'h0,23'h001234,1));
        wr(2, mk(1,1,0,2'b00,7'h7F,20'h55554,1,0,1,0,4'h0,23'h00ABC2,0));
        wr(3, mk(1,1,0,2'b11,7'h00,20'hC3FFF,1,0,0,1,4'hF,23'h05AF40,0));
        wr(4, mk(1,1,0,2'b00,7'h00,20'h77777,1,1,1,1,4'h0,23'h400001,0));
        wr(5, mk(1,1,0,2'b00,7'h00,20'h9A000,1,1,1,1,4'h0,23'h000310,0));
        wr(6, mk(1,1,0,2'b00,7'h00,20'h9A0AB,1,1,1,1,4'h0,23'h011111,1));

        look(32'h12345678, 7'h00, 2'b00, 1'b0, 0, 0, 36'h0, 0, "R2 absent slot");
        look(32'hABCDE123, 7'h15, 2'b00, 1'b1, 1, 1, 36'h801234123, 0, "R4 small page with top bit");
        look(32'hABCDE123, 7'h16, 2'b00, 1'b1, 0, 0, 36'h0, 0, "R3 tag mismatch");
        look(32'h55557ABC, 7'h03, 2'b00, 1'b0, 1, 2, 36'h00ABC3ABC, 0, "R3 shared ignores tag, R5 16KB");
        look(32'h55557ABC, 7'h03, 2'b01, 1'b0, 1, 2, 36'h00ABC3ABC, 1, "R7 supervisor write denied");
        look(32'h55557ABC, 7'h03, 2'b00, 1'b1, 1, 2, 36'h00ABC3ABC, 1, "R7 user bit required");
        look(32'h55557ABC, 7'h03, 2'b10, 1'b0, 1, 2, 36'h00ABC3ABC, 0, "R7 supervisor execute");
        look(32'hC3123456, 7'h44, 2'b10, 1'b1, 1, 3, 36'h05A123456, 0, "R5 16MB user exec, R8 attrs");
        look(32'hC3123456, 7'h44, 2'b00, 1'b1, 1, 3, 36'h05A123456, 1, "R7 read disabled");
        look(32'hC3123456, 7'h44, 2'b11, 1'b0, 1, 3, 36'h05A123456, 1, "R7 reserved kind");
        look(32'h77777000, 7'h00, 2'b00, 1'b0, 0, 0, 36'h0, 0, "R6 no size marker");
        look(32'h9A0ABCDE, 7'h00, 2'b00, 1'b0, 1, 5, 36'h0003ABCDE, 0, "R9 lowest index, R5 1MB");
        look(32'h9A1ABCDE, 7'h00, 2'b00, 1'b0, 0, 0, 36'h0, 0, "R5 1MB boundary miss");

        wr(5, mk(0,1,0,2'b00,7'h00,20'h9A000,1,1,1,1,4'h0,23'h000310,0));
        look(32'h9A0ABCDE, 7'h00, 2'b00, 1'b0, 1, 6, 36'h011111CDE, 0, "R10 rewrite seen next cycle");
        wr(1, mk(1,0,1,2'b11,7'h15,20'hABCDE,1,1,1,1,4'hA,23'h001234,1));
        look(32'hABCDE123, 7'h15, 2'b01, 1'b1, 1, 1, 36'h801234123, 0, "R8 attribute bits inert");

        repeat (4) idle();
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10: %0d responses missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule